// File: doc/BRIEF.md
# Dual-Channel DAC Sample Input Front End

This block sits between the digital sample source and the two converter cores of a dual 10-bit DAC. Each channel holds two register ranks: an input rank that captures a sample word on a write strobe, and an output rank that drives the core and is loaded from the input rank on a transfer strobe. All control pins are synchronous, active-high, one-cycle enables sampled on the rising edge of the single system clock `clk`.

A mode pin sets what the four control pins mean. With `dualMode` high, each channel has its own port, write strobe and transfer strobe, and the two channels run independently. With `dualMode` low, only `portA` carries data. Channel-1 and channel-2 words arrive on it one after the other. `wrStbA` becomes the shared write strobe and `wrStbB` becomes the I/Q select. `xferA` becomes the interleaved clock and `xferB` becomes a demultiplexer reset. An internal half-rate toggle makes both output ranks load together on every second interleaved clock. A `sleep` input freezes the output ranks but leaves the input ranks writable.

Top module: `dual_dac_frontend`

## Requirements
- R1: When `rstN` is low at a rising edge, both input ranks and both output ranks clear to zero and the half-rate toggle returns to its first phase.
- R2: In dual mode (`dualMode`=1), `wrStbA` loads `portA` into the channel-1 input rank, and `xferA` copies that rank to `outA` at the same edge. Bit i of the port reaches bit i of the output, with bit 9 as the MSB. `outA` changes only on a cycle with `xferA` high.
- R3: In dual mode, `wrStbB`/`xferB` do the same for `portB` and `outB`. Strobes of one channel never change the other channel's ranks.
- R4: A write with no transfer leaves the output unchanged. A transfer with no new write repeats the held word. A write and a transfer in the same cycle put the previously captured word on the output, and the new word appears at the next transfer.
- R5: In interleaved mode (`dualMode`=0), a `wrStbA` cycle with `wrStbB`=1 writes `portA` into the channel-1 (I) input rank. A `wrStbA` cycle with `wrStbB`=0 writes `portA` into the channel-2 (Q) input rank. `portB` has no effect.
- R6: In interleaved mode, counting `xferA` cycles from reset or from a demux reset, the first clock updates nothing and the second updates both outputs. The two outputs hold steady on every cycle without `xferA`.
- R7: In interleaved mode, a cycle with `xferB` high returns the toggle to its first phase and updates no output. An `xferA` in that same cycle is not counted, so two further clocks are needed before the next update.
- R8: While `sleep` is high, neither output changes whatever the transfer strobes do. Writes to the input ranks are still taken, and the half-rate toggle still advances.
- R9: When an update is due on both channels in the same cycle (interleaved pair, or dual mode with `xferA` and `xferB` both high), both outputs change at the same edge.
- R10: In interleaved mode `xferB` never transfers to `outB`. In dual mode the toggle is held at its first phase, so it starts a fresh pair when the mode returns to interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| dualMode | input | 1 | 1 = two independent ports, 0 = single interleaved port |
| sleep | input | 1 | Freezes both output ranks while high |
| portA | input | DATA_W | Channel-1 data port, also the interleaved stream |
| portB | input | DATA_W | Channel-2 data port (dual mode only) |
| wrStbA | input | 1 | Channel-1 write strobe / interleaved write strobe |
| xferA | input | 1 | Channel-1 transfer strobe / interleaved clock |
| xferB | input | 1 | Channel-2 transfer strobe / demultiplexer reset |
| wrStbB | input | 1 | Channel-2 write strobe / I-Q select |
| outA | output | DATA_W | Word driving converter core 1 |
| outB | output | DATA_W | Word driving converter core 2 |

## Verification
The bench first goes after rank separation: writes with no transfer, transfers with no write, and both in one cycle. A design that merged the ranks would show the new word one transfer too early. In interleaved mode it counts clocks after reset and after a demux reset, including a demux reset that lands on a clock. A toggle that ignored the reset, or counted that clock, would update one clock early and present a pair made from mismatched words. It also sends the Q word of a pair on `portA` while `portB` carries a decoy value; a design that kept reading `portB` would put the decoy on `outB`. Last, it writes while asleep and then wakes, so a design that blocked writes during sleep would come out with a stale word.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int NUM_CH = 2;

  // strobes handed from control to datapath, index 0 = channel 1
  typedef struct packed {
    logic [NUM_CH-1:0] loadIn;     // capture into input rank
    logic [NUM_CH-1:0] updOut;     // copy input rank to output rank
    logic              qFromPortA; // channel-2 input rank fed by port A
  } feStrobes_t;
endpackage

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dualMode,
  input  logic       sleep,
  input  logic       wrStbA,
  input  logic       xferA,
  input  logic       xferB,
  input  logic       wrStbB,
  output feStrobes_t strobes
);
  // halfQ = 1 once the first clock of a pair has been seen
  logic halfQ;
  logic pairTick;

  assign pairTick = xferA & ~xferB & halfQ;

  always_comb begin
    strobes = '0;
    if (dualMode) begin
      strobes.loadIn     = {wrStbB, wrStbA};
      strobes.updOut     = sleep ? '0 : {xferB, xferA};
      strobes.qFromPortA = 1'b0;
    end else begin
      strobes.loadIn[0]  = wrStbA &  wrStbB;
      strobes.loadIn[1]  = wrStbA & ~wrStbB;
      strobes.updOut     = sleep ? '0 : {NUM_CH{pairTick}};
      strobes.qFromPortA = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfQ <= 1'b0;
    end else if (dualMode || xferB) begin
      halfQ <= 1'b0;
    end else if (xferA) begin
      halfQ <= ~halfQ;
    end
  end
endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  feStrobes_t        strobes,
  input  logic [DATA_W-1:0] portA,
  input  logic [DATA_W-1:0] portB,
  output logic [DATA_W-1:0] outA,
  output logic [DATA_W-1:0] outB
);
  logic [DATA_W-1:0] srcWord [NUM_CH];
  logic [DATA_W-1:0] inRank  [NUM_CH];
  logic [DATA_W-1:0] outRank [NUM_CH];

  assign srcWord[0] = portA;
  assign srcWord[1] = strobes.qFromPortA ? portA : portB;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        inRank[ch]  <= '0;
        outRank[ch] <= '0;
      end else begin
        if (strobes.loadIn[ch]) inRank[ch]  <= srcWord[ch];
        if (strobes.updOut[ch]) outRank[ch] <= inRank[ch];
      end
    end
  end

  assign outA = outRank[0];
  assign outB = outRank[1];
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dualMode,
  input  logic              sleep,
  input  logic [DATA_W-1:0] portA,
  input  logic [DATA_W-1:0] portB,
  input  logic              wrStbA,
  input  logic              xferA,
  input  logic              xferB,
  input  logic              wrStbB,
  output logic [DATA_W-1:0] outA,
  output logic [DATA_W-1:0] outB
);
  feStrobes_t strobes;

  dacfe_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dualMode (dualMode),
    .sleep    (sleep),
    .wrStbA   (wrStbA),
    .xferA    (xferA),
    .xferB    (xferB),
    .wrStbB   (wrStbB),
    .strobes  (strobes)
  );

  dacfe_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .portA   (portA),
    .portB   (portB),
    .outA    (outA),
    .outB    (outB)
  );
endmodule

// File: rtl/dual_dac_frontend_chk.sv
module dual_dac_frontend_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              dualMode,
  input logic              sleep,
  input logic              xferA,
  input logic              xferB,
  input logic [DATA_W-1:0] outA,
  input logic [DATA_W-1:0] outB
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (outA == '0) && (outB == '0)); // R1

  AST_DUAL_A_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rstN && dualMode && !xferA |=> $stable(outA)); // R2

  AST_DUAL_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rstN && dualMode && !xferB |=> $stable(outB)); // R3

  AST_INTL_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !dualMode && !xferA |=> $stable(outA) && $stable(outB)); // R6

  AST_DEMUX_RST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !dualMode && xferB |=> $stable(outA) && $stable(outB)); // R7

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    rstN && sleep |=> $stable(outA) && $stable(outB)); // R8
endmodule

bind dual_dac_frontend dual_dac_frontend_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dualMode (dualMode),
  .sleep    (sleep),
  .xferA    (xferA),
  .xferB    (xferB),
  .outA     (outA),
  .outB     (outB)
);

// File: tb/test_dual_dac_frontend.sv
`timescale 1ns/1ps
module test_dual_dac_frontend;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         dualMode = 1'b1;
  logic         sleep = 1'b0;
  logic [W-1:0] portA = '0;
  logic [W-1:0] portB = '0;
  logic         wrStbA = 1'b0;
  logic         xferA = 1'b0;
  logic         xferB = 1'b0;
  logic         wrStbB = 1'b0;
  logic [W-1:0] outA;
  logic [W-1:0] outB;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_dac_frontend #(.DATA_W(W)) i_dual_dac_frontend (
    .clk(clk), .rstN(rstN), .dualMode(dualMode), .sleep(sleep),
    .portA(portA), .portB(portB), .wrStbA(wrStbA), .xferA(xferA),
    .xferB(xferB), .wrStbB(wrStbB), .outA(outA), .outB(outB)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic resetDut(logic mode);
    rstN = 1'b0; wrStbA = 0; wrStbB = 0; xferA = 0; xferB = 0; sleep = 0;
    dualMode = mode;
    step(); step();
    rstN = 1'b1;
  endtask

  // dual-mode helpers
  task automatic writeA(logic [W-1:0] v);
    portA = v; wrStbA = 1; step(); wrStbA = 0;
  endtask
  task automatic writeB(logic [W-1:0] v);
    portB = v; wrStbB = 1; step(); wrStbB = 0;
  endtask
  task automatic pulseXferA();
    xferA = 1; step(); xferA = 0;
  endtask

  // interleaved helpers
  task automatic writePair(logic [W-1:0] iw, logic [W-1:0] qw);
    portB = 10'h3FF;                    // decoy, must be ignored
    portA = iw; wrStbB = 1; wrStbA = 1; step();
    portA = qw; wrStbB = 0; step();
    wrStbA = 0;
  endtask

  task automatic testReset();
    resetDut(1'b1);
    check("R1", "outA after reset", outA, '0);
    check("R1", "outB after reset", outB, '0);
    writeA(10'h3FF); writeB(10'h2EE);
    rstN = 0; step(); rstN = 1;
    xferA = 1; xferB = 1; step(); xferA = 0; xferB = 0;
    check("R1", "outA from cleared input rank", outA, '0);
    check("R1", "outB from cleared input rank", outB, '0);
  endtask

  task automatic testDualRanks();
    resetDut(1'b1);
    writeA(10'h155);
    check("R4", "outA after write only", outA, '0);
    pulseXferA();
    check("R2", "outA after transfer", outA, 10'h155);
    pulseXferA();
    check("R4", "outA repeat transfer", outA, 10'h155);
    portA = 10'h0AA; wrStbA = 1; xferA = 1; step(); wrStbA = 0; xferA = 0;
    check("R4", "outA same-cycle write+xfer", outA, 10'h155);
    pulseXferA();
    check("R4", "outA next transfer", outA, 10'h0AA);
    writeA(10'h200); pulseXferA();
    check("R2", "outA MSB only", outA, 10'h200);
    writeA(10'h001); pulseXferA();
    check("R2", "outA LSB only", outA, 10'h001);
  endtask

  task automatic testDualIndependent();
    resetDut(1'b1);
    writeB(10'h123);
    xferB = 1; step(); xferB = 0;
    check("R3", "outB after own transfer", outB, 10'h123);
    check("R3", "outA untouched by ch2", outA, '0);
    portB = 10'h3C3;
    writeA(10'h321); pulseXferA();
    check("R3", "outA after ch1 strobes", outA, 10'h321);
    check("R3", "outB untouched by ch1", outB, 10'h123);
    writeA(10'h0F1); writeB(10'h1E2);
    xferA = 1; xferB = 1; step(); xferA = 0; xferB = 0;
    check("R9", "outA dual simultaneous", outA, 10'h0F1);
    check("R9", "outB dual simultaneous", outB, 10'h1E2);
  endtask

  task automatic testInterleaved();
    resetDut(1'b0);
    writePair(10'h2A5, 10'h15A);
    pulseXferA();
    check("R6", "outA after first clock", outA, '0);
    check("R6", "outB after first clock", outB, '0);
    pulseXferA();
    check("R5", "outA gets I word", outA, 10'h2A5);
    check("R5", "outB gets Q word from portA", outB, 10'h15A);
    writePair(10'h0F0, 10'h30F);
    pulseXferA();
    check("R6", "outA held on odd clock", outA, 10'h2A5);
    pulseXferA();
    check("R9", "outA pair update", outA, 10'h0F0);
    check("R9", "outB pair update", outB, 10'h30F);
  endtask

  task automatic testDemuxReset();
    resetDut(1'b0);
    writePair(10'h0F0, 10'h30F);
    pulseXferA(); pulseXferA();
    pulseXferA();                        // first half of next pair
    writePair(10'h111, 10'h222);
    xferB = 1; step(); xferB = 0;
    check("R10", "outB not transferred by ch2 clock pin", outB, 10'h30F);
    pulseXferA();
    check("R7", "outA held after demux reset", outA, 10'h0F0);
    pulseXferA();
    check("R7", "outA after full pair", outA, 10'h111);
    check("R7", "outB after full pair", outB, 10'h222);
    writePair(10'h0AB, 10'h0CD);
    xferA = 1; xferB = 1; step(); xferA = 0; xferB = 0;
    pulseXferA();
    check("R7", "clock during demux reset not counted", outA, 10'h111);
    pulseXferA();
    check("R7", "outB after counted pair", outB, 10'h0CD);
    // dual mode holds the toggle at first phase
    pulseXferA();                        // half a pair
    dualMode = 1; step(); dualMode = 0;
    writePair(10'h1AA, 10'h2BB);
    pulseXferA();
    check("R10", "toggle restarted by dual mode", outA, 10'h0AB);
    pulseXferA();
    check("R10", "outA after fresh pair", outA, 10'h1AA);
  endtask

  task automatic testSleep();
    resetDut(1'b1);
    writeA(10'h0CC); pulseXferA();
    check("R8", "outA before sleep", outA, 10'h0CC);
    sleep = 1;
    writeA(10'h333);
    pulseXferA();
    check("R8", "outA frozen while asleep", outA, 10'h0CC);
    sleep = 0;
    pulseXferA();
    check("R8", "write taken during sleep", outA, 10'h333);
    resetDut(1'b0);
    writePair(10'h012, 10'h034);
    sleep = 1; pulseXferA(); pulseXferA(); sleep = 0;
    check("R8", "interleaved outB frozen", outB, '0);
    pulseXferA(); pulseXferA();
    check("R8", "interleaved after wake", outB, 10'h034);
  endtask

  initial begin
    step();
    testReset();
    testDualRanks();
    testDualIndependent();
    testInterleaved();
    testDemuxReset();
    testSleep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule